// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two predictors run side by side. The first is a large table of 2-bit counters addressed by the recent outcomes of all branches. The second works in two steps: a short per-branch history of the last six outcomes of that branch, which selects one 3-bit counter in a small pattern table. A chooser table of 2-bit counters, addressed the same way as the global table, decides which of the two guesses is used.

The fetch side raises `pred_valid` with a PC. One cycle later the block returns the final guess, both component guesses, the chooser decision and the indices used. When the branch resolves, the pipeline returns that metadata with the real outcome on the update port. The block then trains the counters, trains the chooser, and shifts the outcome into both histories. A lookup and an update may occur in the same cycle.

Top module: `tourney_dir_pred`

## Requirements
- R1: After reset every global and chooser counter is 01, every pattern counter is 011, and all histories are zero. The first prediction after reset is therefore not-taken, uses the local guess, and reports global index 0 and local history 0.
- R2: A `pred_valid` in one cycle gives `resp_valid` high in the next cycle with that lookup's results. Without `pred_valid`, `resp_valid` is low in the next cycle and every other response output keeps its value.
- R3: The global index is the low 13 bits of the global history register. `resp_gpred` is the MSB of the global counter at that index.
- R4: The local index is PC bits [7:2]. `resp_lhist` is the 6-bit history stored at that index. `resp_lpred` is the MSB of the pattern counter that this history addresses.
- R5: `resp_use_global` is the MSB of the chooser counter at the global index. `resp_taken` equals `resp_gpred` when it is 1 and `resp_lpred` otherwise.
- R6: On update, the global counter at `upd_gidx` moves one step toward the outcome. It stays in the range 0 to 3 and never wraps.
- R7: On update, the pattern counter at `upd_lhist` moves one step toward the outcome. It stays in the range 0 to 7 and never wraps.
- R8: The chooser counter at `upd_gidx` changes only when `upd_gpred` differs from `upd_lpred`. It rises by one, saturating at 3, when the global guess matched the outcome, and falls by one, saturating at 0, otherwise.
- R9: On update, the outcome enters at bit 0 of the global history and at bit 0 of the local history at index `upd_pc[7:2]`. Each older bit moves up one place. Without an update, neither history changes.
- R10: When a lookup and an update occur in the same cycle, the lookup sees every table entry and history value as it was before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | Lookup strobe |
| pred_pc | input | 32 | PC of the branch being looked up |
| upd_valid | input | 1 | Update strobe |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_gidx | input | 13 | Global index returned at lookup |
| upd_lhist | input | 6 | Local history returned at lookup |
| upd_gpred | input | 1 | Global guess returned at lookup |
| upd_lpred | input | 1 | Local guess returned at lookup |
| resp_valid | output | 1 | Response valid, one cycle after `pred_valid` |
| resp_taken | output | 1 | Final direction guess |
| resp_gpred | output | 1 | Global component guess |
| resp_lpred | output | 1 | Local component guess |
| resp_use_global | output | 1 | Chooser picked the global guess |
| resp_gidx | output | 13 | Global and chooser index used |
| resp_lidx | output | 6 | Local history table index used |
| resp_lhist | output | 6 | Local history used as pattern index |

## Verification
The bench targets saturation at both ends of each counter width. A design that wraps a counter would flip a strongly-held guess to the opposite direction after one more training step. It also drives lookups and updates in the same cycle to the same entries; a design that forwarded the new value would return a guess and index one step ahead of the model. The bench also mixes branches whose guesses agree and disagree, so a chooser trained on every update, or trained in the wrong direction, shows up as a wrong `resp_use_global`. Branches that alias on PC bits [7:2] share one local history, which exposes a wrong index slice.

// File: rtl/tourney_dir_pred.sv
module tourney_dir_pred #(
  parameter int PC_W      = 32,
  parameter int PC_SHIFT  = 2,
  parameter int GHIST_W   = 13,
  parameter int LANE_W    = 3,
  parameter int LOC_IDX_W = 6,
  parameter int LHIST_W   = 6,
  parameter int GCNT_W    = 2,
  parameter int LCNT_W    = 3,
  parameter int SCNT_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pred_valid,
  input  logic [PC_W-1:0]      pred_pc,
  input  logic                 upd_valid,
  input  logic [PC_W-1:0]      upd_pc,
  input  logic                 upd_taken,
  input  logic [GHIST_W-1:0]   upd_gidx,
  input  logic [LHIST_W-1:0]   upd_lhist,
  input  logic                 upd_gpred,
  input  logic                 upd_lpred,
  output logic                 resp_valid,
  output logic                 resp_taken,
  output logic                 resp_gpred,
  output logic                 resp_lpred,
  output logic                 resp_use_global,
  output logic [GHIST_W-1:0]   resp_gidx,
  output logic [LOC_IDX_W-1:0] resp_lidx,
  output logic [LHIST_W-1:0]   resp_lhist
);

  localparam int LANES   = 1 << LANE_W;
  localparam int ROW_W   = GHIST_W - LANE_W;
  localparam int ROWS    = 1 << ROW_W;
  localparam int LHT_N   = 1 << LOC_IDX_W;
  localparam int LPT_N   = 1 << LHIST_W;
  localparam logic [GCNT_W-1:0] G_WEAK = GCNT_W'((1 << (GCNT_W-1)) - 1);
  localparam logic [SCNT_W-1:0] S_WEAK = SCNT_W'((1 << (SCNT_W-1)) - 1);
  localparam logic [LCNT_W-1:0] L_WEAK = LCNT_W'((1 << (LCNT_W-1)) - 1);
  localparam logic [GCNT_W-1:0] G_MAX  = '1;
  localparam logic [SCNT_W-1:0] S_MAX  = '1;
  localparam logic [LCNT_W-1:0] L_MAX  = '1;

  logic [LANES*GCNT_W-1:0] gtab [ROWS];
  logic [LANES*SCNT_W-1:0] stab [ROWS];
  logic [LHIST_W-1:0]      lht  [LHT_N];
  logic [LCNT_W-1:0]       lpt  [LPT_N];
  logic [GHIST_W-1:0]      ghist;

  // lookup path
  logic [ROW_W-1:0]     p_row;
  logic [LANE_W-1:0]    p_lane;
  logic [LOC_IDX_W-1:0] p_lidx;
  logic [LHIST_W-1:0]   p_lh;
  logic [GCNT_W-1:0]    p_gc;
  logic [SCNT_W-1:0]    p_sc;
  logic [LCNT_W-1:0]    p_lc;

  assign p_row  = ghist[GHIST_W-1:LANE_W];
  assign p_lane = ghist[LANE_W-1:0];
  assign p_lidx = pred_pc[PC_SHIFT +: LOC_IDX_W];
  assign p_lh   = lht[p_lidx];
  assign p_gc   = gtab[p_row][p_lane*GCNT_W +: GCNT_W];
  assign p_sc   = stab[p_row][p_lane*SCNT_W +: SCNT_W];
  assign p_lc   = lpt[p_lh];

  // update path
  logic [ROW_W-1:0]     u_row;
  logic [LANE_W-1:0]    u_lane;
  logic [LOC_IDX_W-1:0] u_lidx;
  logic [GCNT_W-1:0]    u_gc, g_new;
  logic [SCNT_W-1:0]    u_sc, s_new;
  logic [LCNT_W-1:0]    u_lc, l_new;
  logic                 sel_train, sel_up;

  assign u_row     = upd_gidx[GHIST_W-1:LANE_W];
  assign u_lane    = upd_gidx[LANE_W-1:0];
  assign u_lidx    = upd_pc[PC_SHIFT +: LOC_IDX_W];
  assign u_gc      = gtab[u_row][u_lane*GCNT_W +: GCNT_W];
  assign u_sc      = stab[u_row][u_lane*SCNT_W +: SCNT_W];
  assign u_lc      = lpt[upd_lhist];
  assign sel_train = upd_gpred != upd_lpred;
  assign sel_up    = upd_gpred == upd_taken;

  always_comb begin
    if (upd_taken) g_new = (u_gc == G_MAX) ? u_gc : u_gc + 1'b1;
    else           g_new = (u_gc == '0)    ? u_gc : u_gc - 1'b1;
    if (upd_taken) l_new = (u_lc == L_MAX) ? u_lc : u_lc + 1'b1;
    else           l_new = (u_lc == '0)    ? u_lc : u_lc - 1'b1;
    s_new = u_sc;
    if (sel_train) begin
      if (sel_up) s_new = (u_sc == S_MAX) ? u_sc : u_sc + 1'b1;
      else        s_new = (u_sc == '0)    ? u_sc : u_sc - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) gtab[i] <= {LANES{G_WEAK}};
    end else if (upd_valid) begin
      gtab[u_row][u_lane*GCNT_W +: GCNT_W] <= g_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) stab[i] <= {LANES{S_WEAK}};
    end else if (upd_valid) begin
      stab[u_row][u_lane*SCNT_W +: SCNT_W] <= s_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LPT_N; i++) lpt[i] <= L_WEAK;
      for (int i = 0; i < LHT_N; i++) lht[i] <= '0;
      ghist <= '0;
    end else if (upd_valid) begin
      lpt[upd_lhist] <= l_new;
      lht[u_lidx]    <= {lht[u_lidx][LHIST_W-2:0], upd_taken};
      ghist          <= {ghist[GHIST_W-2:0], upd_taken};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid      <= 1'b0;
      resp_taken      <= 1'b0;
      resp_gpred      <= 1'b0;
      resp_lpred      <= 1'b0;
      resp_use_global <= 1'b0;
      resp_gidx       <= '0;
      resp_lidx       <= '0;
      resp_lhist      <= '0;
    end else begin
      resp_valid <= pred_valid;
      if (pred_valid) begin
        resp_gpred      <= p_gc[GCNT_W-1];
        resp_lpred      <= p_lc[LCNT_W-1];
        resp_use_global <= p_sc[SCNT_W-1];
        resp_taken      <= p_sc[SCNT_W-1] ? p_gc[GCNT_W-1] : p_lc[LCNT_W-1];
        resp_gidx       <= ghist;
        resp_lidx       <= p_lidx;
        resp_lhist      <= p_lh;
      end
    end
  end

  p_resp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |=> (!resp_valid && $stable(resp_taken) && $stable(resp_gidx) && $stable(resp_lhist)));

  p_gcnt_nowrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_taken ? (g_new >= u_gc) : (g_new <= u_gc)));

  p_lcnt_nowrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_taken ? (l_new >= u_lc) : (l_new <= u_lc)));

  p_sel_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_gpred == upd_lpred)) |=> (stab[$past(u_row)] == $past(stab[u_row])));

  p_hist_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist));

  p_hist_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (ghist[0] == $past(upd_taken)));

endmodule

// File: tb/sim_tourney_dir_pred.sv
module sim_tourney_dir_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pred_valid = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [12:0] upd_gidx = '0;
  logic [5:0]  upd_lhist = '0;
  logic        upd_gpred = 1'b0;
  logic        upd_lpred = 1'b0;
  logic        resp_valid, resp_taken, resp_gpred, resp_lpred, resp_use_global;
  logic [12:0] resp_gidx;
  logic [5:0]  resp_lidx, resp_lhist;

  always #10 clk = ~clk;

  tourney_dir_pred u0 (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_gidx(upd_gidx), .upd_lhist(upd_lhist), .upd_gpred(upd_gpred),
    .upd_lpred(upd_lpred), .resp_valid(resp_valid), .resp_taken(resp_taken),
    .resp_gpred(resp_gpred), .resp_lpred(resp_lpred),
    .resp_use_global(resp_use_global), .resp_gidx(resp_gidx),
    .resp_lidx(resp_lidx), .resp_lhist(resp_lhist));

  typedef struct {
    logic [31:0] pc;
    int gi;
    int lh;
    bit gp;
    bit lp;
  } meta_t;

  int gt [8192];
  int st [8192];
  int lpt [64];
  int lht [64];
  int ghist;
  meta_t q[$];

  int ncmp = 0;
  int nbad = 0;
  bit done = 1'b0;

  bit e_valid, e_taken, e_gp, e_lp, e_sel, e_coll, e_first;
  int e_gi, e_li, e_lh;

  task automatic chk(input string tag, input int act, input int exp);
    ncmp++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sat(input int v, input bit up, input int mx);
    if (up) return (v == mx) ? v : v + 1;
    return (v == 0) ? v : v - 1;
  endfunction

  task automatic compare();
    chk("R2 resp_valid", int'(resp_valid), int'(e_valid));
    if (e_first) begin
      chk("R1 first taken", int'(resp_taken), 0);
      chk("R1 first use_global", int'(resp_use_global), 0);
      chk("R1 first gidx", int'(resp_gidx), 0);
      chk("R1 first lhist", int'(resp_lhist), 0);
    end
    if (e_coll) begin
      chk("R10 gidx", int'(resp_gidx), e_gi);
      chk("R10 lhist", int'(resp_lhist), e_lh);
      chk("R10 taken", int'(resp_taken), int'(e_taken));
    end
    chk("R3/R9 gidx", int'(resp_gidx), e_gi);
    chk("R3/R6 gpred", int'(resp_gpred), int'(e_gp));
    chk("R4 lidx", int'(resp_lidx), e_li);
    chk("R4/R9 lhist", int'(resp_lhist), e_lh);
    chk("R4/R7 lpred", int'(resp_lpred), int'(e_lp));
    chk("R5/R8 use_global", int'(resp_use_global), int'(e_sel));
    chk("R5 taken", int'(resp_taken), int'(e_taken));
  endtask

  task automatic cycle(input bit pv, input logic [31:0] ppc, input bit uv,
                       input meta_t m, input bit ut);
    e_first = 1'b0;
    e_coll  = pv && uv;
    e_valid = pv;
    if (pv) begin
      e_gi    = ghist;
      e_li    = int'(ppc[7:2]);
      e_lh    = lht[e_li];
      e_gp    = gt[e_gi] >= 2;
      e_lp    = lpt[e_lh] >= 4;
      e_sel   = st[e_gi] >= 2;
      e_taken = e_sel ? e_gp : e_lp;
      q.push_back('{pc: ppc, gi: e_gi, lh: e_lh, gp: e_gp, lp: e_lp});
    end
    if (uv) begin
      gt[m.gi] = sat(gt[m.gi], ut, 3);
      if (m.gp != m.lp) st[m.gi] = sat(st[m.gi], m.gp == ut, 3);
      lpt[m.lh] = sat(lpt[m.lh], ut, 7);
      lht[int'(m.pc[7:2])] = ((lht[int'(m.pc[7:2])] << 1) | int'(ut)) & 63;
      ghist = ((ghist << 1) | int'(ut)) & 8191;
    end
    pred_valid = pv;
    pred_pc    = ppc;
    upd_valid  = uv;
    upd_pc     = m.pc;
    upd_taken  = ut;
    upd_gidx   = 13'(m.gi);
    upd_lhist  = 6'(m.lh);
    upd_gpred  = m.gp;
    upd_lpred  = m.lp;
    @(negedge clk);
    compare();
  endtask

  function automatic bit outcome(input logic [31:0] pc);
    case (pc[3:2])
      2'd0: return 1'b1;
      2'd1: return 1'b0;
      2'd2: return !lht[int'(pc[7:2])][0];
      default: return 1'($urandom_range(1));
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      nbad++;
      ncmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end

  initial begin
    meta_t none;
    none = '{pc: 0, gi: 0, lh: 0, gp: 0, lp: 0};
    for (int i = 0; i < 8192; i++) begin gt[i] = 1; st[i] = 1; end
    for (int i = 0; i < 64; i++) begin lpt[i] = 3; lht[i] = 0; end
    ghist = 0;
    e_valid = 0; e_taken = 0; e_gp = 0; e_lp = 0; e_sel = 0;
    e_gi = 0; e_li = 0; e_lh = 0; e_coll = 0; e_first = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset resp_valid", int'(resp_valid), 0);
    @(negedge clk);
    chk("R1 idle resp_valid", int'(resp_valid), 0);
    // first lookup after reset, R1
    cycle(1'b1, 32'h0000_1008, 1'b0, none, 1'b0);
    e_first = 1'b1;
    chk("R1 first taken", int'(resp_taken), 0);
    chk("R1 first use_global", int'(resp_use_global), 0);
    for (int n = 0; n < 4000; n++) begin
      bit pv, uv, ut;
      logic [31:0] pc;
      meta_t m;
      int ppv, puv;
      // phases: mixed, tight same-cycle (R10), sparse with idle gaps (R2)
      if (n < 1500)      begin ppv = 70; puv = 70; end
      else if (n < 3000) begin ppv = 100; puv = 100; end
      else               begin ppv = 25; puv = 40; end
      pv = $urandom_range(99) < ppv;
      pc = 32'h0000_1000 + (32'($urandom_range(7)) << 2) + (32'($urandom_range(1)) << 8);
      uv = (q.size() > 0) && ($urandom_range(99) < puv);
      if (uv) begin
        m  = q.pop_front();
        ut = outcome(m.pc);
      end else begin
        m  = none;
        ut = 1'b0;
      end
      cycle(pv, pc, uv, m, ut);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule